// File: doc/BRIEF.md
# Layer 3 IP address match filter

This block decides whether a received frame passes a Layer 3 address filter. An upstream header parser presents the frame's IP type, its source address and its destination address as one transfer. The block compares either or both addresses against programmed reference addresses and returns one pass/fail verdict per frame. Each address field has a programmable count of low-order bits that take no part in the comparison. Each field can also be set to pass on a mismatch instead of on a match.

IPv4 frames compare 32-bit addresses, and each field has its own 5-bit don't-care count. IPv6 frames compare 128-bit addresses against a single 7-bit count that is assembled from the two count inputs. Only one IPv6 address is compared. When both fields are enabled in IPv6 mode, the destination is the one compared.

Both the frame input and the verdict output are valid/ready streams. A frame is taken on a cycle where `in_valid` and `in_ready` are both high. Its verdict appears on the next cycle. The verdict stays on the outputs until the consumer accepts it with `out_ready`. While the verdict is not accepted, `in_ready` is low. When a held verdict is accepted, a new frame can be taken in the same cycle, so the block sustains one frame per cycle. The control pins are plain levels and are sampled in the cycle the frame is taken.

Top module: `l3_addr_filter`

## Requirements
- R1: IPv4 (`in_is_v6`=0) with the destination field enabled: a count N (0..31) on `cfg_dst_cnt` makes address bits [N-1:0] don't-care. With 0 every bit is compared, and with 31 only bit 31 is compared. The field matches when all compared bits equal `cfg_dst_ref`.
- R2: IPv4 with the source field enabled behaves the same way, using `cfg_src_cnt` and `cfg_src_ref`.
- R3: When a field's inverse bit (`cfg_dst_inv` or `cfg_src_inv`) is 1, that field passes on a mismatch and fails on a match.
- R4: When a field's enable is 0, its address, reference, inverse bit and count have no effect on the verdict.
- R5: With both enables at 0 the verdict is pass. In IPv4 with both enables at 1, the verdict is the AND of the two field results.
- R6: IPv6 (`in_is_v6`=1): a single 7-bit count is formed as `{cfg_dst_cnt[1:0], cfg_src_cnt[4:0]}`. It makes bits [N-1:0] of the 128-bit compared address don't-care, so 127 leaves only bit 127 compared. Exactly one address is compared.
- R7: IPv6 with both enables at 1 compares the destination address only. The source address and source inverse bit are ignored.
- R8: IPv4 compares bits [31:0] of the address and reference inputs. Bits [127:32] are ignored.
- R9: A frame taken on a clock edge produces `out_valid`=1 with its verdict on `out_pass` from the following cycle.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_pass` hold and `in_ready`=0. On the edge where the verdict is accepted, a new frame may be taken.
- R11: After reset `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame fields present |
| in_ready | output | 1 | Block can take a frame |
| in_is_v6 | input | 1 | 0 = IPv4, 1 = IPv6 |
| in_src_addr | input | 128 | Frame source address (IPv4 in [31:0]) |
| in_dst_addr | input | 128 | Frame destination address (IPv4 in [31:0]) |
| cfg_dst_en | input | 1 | Destination field takes part |
| cfg_dst_inv | input | 1 | Destination field passes on mismatch |
| cfg_src_en | input | 1 | Source field takes part |
| cfg_src_inv | input | 1 | Source field passes on mismatch |
| cfg_dst_cnt | input | 5 | IPv4 destination don't-care count; IPv6 count bits [6:5] from [1:0] |
| cfg_src_cnt | input | 5 | IPv4 source don't-care count; IPv6 count bits [4:0] |
| cfg_dst_ref | input | 128 | Destination reference address |
| cfg_src_ref | input | 128 | Source reference address |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_pass | output | 1 | 1 = frame passes the filter |

## Verification
The hardest situation to reach is a verdict held under back-pressure that is released on the same edge a new frame is taken. Both verdicts must then appear in order, with no loss or duplication. The stimulus holds `out_ready` low for several cycles while a second frame with the opposite verdict waits on the input. It then raises `out_ready` and checks that the waiting frame's verdict follows. A second hard case is the IPv6 count, whose two halves come from different pins. Counts of 67 and 127 are chosen so that a difference at the bit just below or at the boundary decides the verdict. A set of varied frames compared against an independent model also covers cases that the directed tests miss.

// File: rtl/l3f_pkg.sv
package l3f_pkg;
  typedef enum logic {IP_V4 = 1'b0, IP_V6 = 1'b1} ip_kind_e;
  typedef struct packed {
    logic en;
    logic inv;
  } fld_ctl_t;
endpackage

// File: rtl/l3f_mask_gen.sv
// Converts a don't-care count into a keep mask: bit i is kept when i >= count.
module l3f_mask_gen #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  keep
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign keep[i] = (CW'(i) >= cnt);
  end
endmodule

// File: rtl/l3f_field_cmp.sv
// Masked equality of one address field with optional inversion.
module l3f_field_cmp
  import l3f_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] ref_addr,
  input  logic [W-1:0] keep,
  input  fld_ctl_t     ctl,
  output logic         ok
);
  logic differs;
  assign differs = |((addr ^ ref_addr) & keep);
  // match = !differs; result = match XOR inv, disabled field always passes
  assign ok = !ctl.en || (differs == ctl.inv);
endmodule

// File: rtl/l3f_out_stage.sv
// One-entry verdict register with valid/ready hand-off.
module l3f_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic pass_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_pass,
  output logic in_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pass  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pass  <= pass_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pass)));

  assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/l3_addr_filter.sv
module l3_addr_filter
  import l3f_pkg::*;
#(
  parameter int V4_W = 32,
  parameter int V6_W = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_is_v6,
  input  logic [V6_W-1:0] in_src_addr,
  input  logic [V6_W-1:0] in_dst_addr,
  input  logic            cfg_dst_en,
  input  logic            cfg_dst_inv,
  input  logic            cfg_src_en,
  input  logic            cfg_src_inv,
  input  logic [$clog2(V4_W)-1:0] cfg_dst_cnt,
  input  logic [$clog2(V4_W)-1:0] cfg_src_cnt,
  input  logic [V6_W-1:0] cfg_dst_ref,
  input  logic [V6_W-1:0] cfg_src_ref,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_pass
);
  localparam int CNT4_W = $clog2(V4_W);
  localparam int CNT6_W = $clog2(V6_W);
  localparam int HI_W   = CNT6_W - CNT4_W;

  fld_ctl_t dst_ctl, src_ctl, v6_ctl;
  ip_kind_e kind;
  assign dst_ctl = '{en: cfg_dst_en, inv: cfg_dst_inv};
  assign src_ctl = '{en: cfg_src_en, inv: cfg_src_inv};
  assign kind    = ip_kind_e'(in_is_v6);

  // IPv4 path: one mask per field
  logic [V4_W-1:0] keep4_dst, keep4_src;
  logic ok4_dst, ok4_src;

  l3f_mask_gen #(.W(V4_W)) u_mask4_dst (.cnt(cfg_dst_cnt), .keep(keep4_dst));
  l3f_mask_gen #(.W(V4_W)) u_mask4_src (.cnt(cfg_src_cnt), .keep(keep4_src));

  l3f_field_cmp #(.W(V4_W)) u_cmp4_dst (
    .addr(in_dst_addr[V4_W-1:0]), .ref_addr(cfg_dst_ref[V4_W-1:0]),
    .keep(keep4_dst), .ctl(dst_ctl), .ok(ok4_dst));
  l3f_field_cmp #(.W(V4_W)) u_cmp4_src (
    .addr(in_src_addr[V4_W-1:0]), .ref_addr(cfg_src_ref[V4_W-1:0]),
    .keep(keep4_src), .ctl(src_ctl), .ok(ok4_src));

  // IPv6 path: one shared comparator, destination wins when both enabled
  logic [CNT6_W-1:0] cnt6;
  logic [V6_W-1:0]   keep6, addr6, ref6;
  logic              ok6;
  assign cnt6   = {cfg_dst_cnt[HI_W-1:0], cfg_src_cnt};
  assign addr6  = cfg_dst_en ? in_dst_addr : in_src_addr;
  assign ref6   = cfg_dst_en ? cfg_dst_ref : cfg_src_ref;
  assign v6_ctl = cfg_dst_en ? dst_ctl : src_ctl;

  l3f_mask_gen #(.W(V6_W)) u_mask6 (.cnt(cnt6), .keep(keep6));
  l3f_field_cmp #(.W(V6_W)) u_cmp6 (
    .addr(addr6), .ref_addr(ref6), .keep(keep6), .ctl(v6_ctl), .ok(ok6));

  logic verdict, take;
  assign verdict = (kind == IP_V6) ? ok6 : (ok4_dst && ok4_src);
  assign take    = in_valid && in_ready;

  l3f_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .pass_in(verdict),
    .out_ready(out_ready), .out_valid(out_valid), .out_pass(out_pass),
    .in_ready(in_ready));

  assert_nofield_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_dst_en && !cfg_src_en) |=> out_pass);

  assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_is_v6 && cfg_dst_en && !cfg_dst_inv && !cfg_src_en &&
     in_dst_addr[V4_W-1:0] == cfg_dst_ref[V4_W-1:0]) |=> out_pass);

  assert_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_is_v6 && cfg_dst_en && cfg_dst_inv &&
     in_dst_addr[V4_W-1:0] == cfg_dst_ref[V4_W-1:0]) |=> !out_pass);

  assert_v6dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_is_v6 && cfg_dst_en && !cfg_dst_inv &&
     in_dst_addr == cfg_dst_ref) |=> out_pass);
endmodule

// File: tb/sim_l3_addr_filter.sv
module sim_l3_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_is_v6 = 0, out_ready = 1;
  logic dst_en = 0, dst_inv = 0, src_en = 0, src_inv = 0;
  logic [4:0] dst_cnt = 0, src_cnt = 0;
  logic [127:0] src_addr = 0, dst_addr = 0, dst_ref = 0, src_ref = 0;
  logic in_ready, out_valid, out_pass;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l3_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_v6(in_is_v6), .in_src_addr(src_addr), .in_dst_addr(dst_addr),
    .cfg_dst_en(dst_en), .cfg_dst_inv(dst_inv), .cfg_src_en(src_en),
    .cfg_src_inv(src_inv), .cfg_dst_cnt(dst_cnt), .cfg_src_cnt(src_cnt),
    .cfg_dst_ref(dst_ref), .cfg_src_ref(src_ref), .out_valid(out_valid),
    .out_ready(out_ready), .out_pass(out_pass));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired act %0d exp <= %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  // independent model of the verdict
  function automatic bit model();
    logic [127:0] md, ms;
    bit dok, sok;
    if (in_is_v6) begin
      md = ~128'd0 << {dst_cnt[1:0], src_cnt};
      if (dst_en) return ((|((dst_addr ^ dst_ref) & md)) == dst_inv);
      if (src_en) return ((|((src_addr ^ src_ref) & md)) == src_inv);
      return 1'b1;
    end
    md = {96'd0, 32'hFFFF_FFFF << dst_cnt};
    ms = {96'd0, 32'hFFFF_FFFF << src_cnt};
    dok = !dst_en || ((|((dst_addr ^ dst_ref) & md)) == dst_inv);
    sok = !src_en || ((|((src_addr ^ src_ref) & ms)) == src_inv);
    return dok && sok;
  endfunction

  task automatic cfg(input bit v6, input bit de, input bit di, input bit se, input bit si,
                     input logic [4:0] dc, input logic [4:0] sc);
    in_is_v6 = v6; dst_en = de; dst_inv = di; src_en = se; src_inv = si;
    dst_cnt = dc; src_cnt = sc;
  endtask

  // present the frame currently on the bench regs and check its verdict
  task automatic send(input string tag, input bit exp);
    @(negedge clk);
    in_valid = 1; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " pass"}, out_pass, exp);
  endtask

  task automatic t_reset();
    chk("R11 out_valid after reset", out_valid, 0);
    chk("R11 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_v4_dst();
    dst_ref = 128'hC0A8_0A05; src_addr = 0; src_ref = 0;
    cfg(0, 1, 0, 0, 0, 0, 0);
    dst_addr = 128'hC0A8_0A05; send("R1 cnt0 equal", 1);
    dst_addr = 128'hC0A8_0A04; send("R1 cnt0 bit0 differs", 0);
    dst_cnt = 1; send("R1 cnt1 bit0 differs", 1);
    dst_addr = 128'hC0A8_0A07; send("R1 cnt1 bit1 differs", 0);
    dst_cnt = 31; dst_addr = 128'hBFFF_FFFF; send("R1 cnt31 low bits differ", 1);
    dst_addr = 128'h40A8_0A05; send("R1 cnt31 msb differs", 0);
  endtask

  task automatic t_v4_src();
    src_ref = 128'h0A00_0100; dst_addr = 1; dst_ref = 2;
    cfg(0, 0, 0, 1, 0, 0, 8);
    src_addr = 128'h0A00_01FF; send("R2 cnt8 low byte differs", 1);
    src_addr = 128'h0A00_02FF; send("R2 cnt8 bit9 differs", 0);
    src_cnt = 0; src_addr = 128'h0A00_0100; send("R2 cnt0 equal", 1);
  endtask

  task automatic t_inverse();
    dst_ref = 128'h1234_5678; dst_addr = 128'h1234_5678;
    cfg(0, 1, 1, 0, 0, 0, 0);
    send("R3 dst inverse on match", 0);
    dst_addr = 128'h1234_5679; send("R3 dst inverse on mismatch", 1);
    src_ref = 128'hAAAA_0000; src_addr = 128'hAAAA_0000;
    cfg(0, 0, 0, 1, 1, 0, 4);
    send("R3 src inverse on match", 0);
    src_addr = 128'hAAAB_0000; send("R3 src inverse on mismatch", 1);
  endtask

  task automatic t_disabled();
    dst_addr = 128'hDEAD_BEEF; dst_ref = 128'h0; src_addr = 1; src_ref = 1;
    cfg(0, 0, 1, 1, 0, 0, 0);
    send("R4 disabled dst with inverse and mismatch", 1);
    dst_addr = 128'h0; send("R4 disabled dst with inverse and match", 1);
    cfg(0, 0, 0, 0, 0, 3, 3); src_addr = 7; send("R5 no field enabled", 1);
  endtask

  task automatic t_both_v4();
    dst_ref = 128'h0A0A_0A0A; src_ref = 128'h0B0B_0B0B;
    dst_addr = dst_ref; src_addr = src_ref;
    cfg(0, 1, 0, 1, 0, 0, 0);
    send("R5 both enabled both match", 1);
    src_addr = 128'h0B0B_0B0C; send("R5 both enabled src mismatch", 0);
    src_addr = src_ref; dst_addr = 128'h0A0A_0A0B; send("R5 both enabled dst mismatch", 0);
    dst_addr = {96'hFFFF_0000_1234_5678_9ABC_DEF0, 32'h0A0A_0A0A};
    src_addr = {96'h1, 32'h0B0B_0B0B};
    send("R8 v4 upper bits differ", 1);
  endtask

  task automatic t_v6();
    dst_ref = 128'h2001_0DB8_0000_0000_0000_0000_0000_0001;
    // count = {2'b10, 5'd3} = 67
    cfg(1, 1, 0, 0, 0, 5'b00010, 5'd3);
    dst_addr = dst_ref ^ (128'd1 << 66); send("R6 v6 cnt67 bit66 differs", 1);
    dst_addr = dst_ref ^ (128'd1 << 67); send("R6 v6 cnt67 bit67 differs", 0);
    dst_addr = dst_ref ^ (128'd1 << 35); send("R6 v6 upper v4 region ignored", 1);
    src_ref = ~128'd0 >> 1;
    cfg(1, 0, 0, 1, 0, 5'b11111, 5'b11111); // 127
    src_addr = 128'd0; send("R6 v6 cnt127 msb equal", 1);
    src_addr = {1'b1, 127'd0}; send("R6 v6 cnt127 msb differs", 0);
    cfg(1, 0, 0, 0, 0, 0, 0); send("R5 v6 no field enabled", 1);
  endtask

  task automatic t_v6_both();
    dst_ref = 128'h5; dst_addr = 128'h5; src_ref = 128'h9; src_addr = 128'hF0;
    cfg(1, 1, 0, 1, 0, 0, 0);
    send("R7 v6 both enabled src mismatch ignored", 1);
    src_inv = 1; send("R7 v6 source inverse ignored", 1);
    dst_addr = 128'h4; src_addr = src_ref; src_inv = 0;
    send("R7 v6 dst mismatch with src match", 0);
  endtask

  task automatic t_backpressure();
    dst_ref = 128'h10; dst_addr = 128'h10;
    cfg(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    out_ready = 0; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 verdict after one cycle", out_valid, 1);
    chk("R10 in_ready low while held", in_ready, 0);
    dst_addr = 128'h11; // second frame fails, waits
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid held", out_valid, 1);
    chk("R10 pass held", out_pass, 1);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R10 back-to-back valid", out_valid, 1);
    chk("R10 back-to-back second verdict", out_pass, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", out_valid, 0);
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 300; k++) begin
      logic [127:0] flip;
      cfg($urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1,
          $urandom % 2 == 1, $urandom % 2 == 1, 5'($urandom), 5'($urandom));
      dst_ref = {$urandom, $urandom, $urandom, $urandom};
      src_ref = {$urandom, $urandom, $urandom, $urandom};
      flip = (k % 3 == 0) ? 128'd0 : (128'd1 << ($urandom % 128));
      dst_addr = dst_ref ^ flip;
      flip = (k % 5 == 0) ? 128'd0 : (128'd1 << ($urandom % 128));
      src_addr = src_ref ^ flip;
      send($sformatf("R6 R1 R2 mixed frame %0d", k), model());
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_v4_dst();
    t_v4_src();
    t_inverse();
    t_disabled();
    t_both_v4();
    t_v6();
    t_v6_both();
    t_backpressure();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule